// File: doc/BRIEF.md
# Linear ramp ADC controller

This block holds the digital side of a 6-bit counting (ramp) converter. Its code counter drives an external DAC that gives 0.1 V per LSB, so code 63 stands for 6.3 V. An external comparator reports whether the DAC voltage has reached the analogue input. The counter rises by one per clock, starting at zero. In the first cycle in which the comparator reports "reached", the present code is loaded into a result register, a done strobe is raised for one cycle, and the counter starts again from zero.

The captured code is the smallest code whose DAC voltage is at least the input, which gives ceiling(10·v) for an input v between 0.0 V and 6.3 V. The result register drives the result output continuously and keeps its value until the next capture. The counter is built from per-bit toggle logic: bit 0 toggles on every step, and each higher bit toggles when all bits below it are high. If the comparator never trips, the block captures code 63 at the top of the ramp and restarts, so a conversion cannot hang.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While `rst_n` is sampled low on a rising edge, the next cycle shows `dac_code_o` = 0, `result_o` = 0 and `done_o` = 0.
- R2: While no capture occurs, `dac_code_o` rises by exactly one on each rising edge, starting from 0.
- R3: When `cmp_ge_i` is high on a rising edge, `result_o` takes the `dac_code_o` value present at that edge.
- R4: On the edge that captures, the counter is cleared, so `dac_code_o` is 0 in every cycle in which `done_o` is high.
- R5: `done_o` is high for the single cycle that follows each result update, and is low after any edge that does not capture.
- R6: With the comparator high when code·0.1 V ≥ v, the captured result equals ceiling(10·v) for every v from 0.0 V to 6.3 V.
- R7: A capture at code c ends c+1 rising edges after the ramp starts at 0, so an input of 0 V gives result 0 after one edge.
- R8: If `dac_code_o` reaches 63 without the comparator tripping, the block captures 63 on that edge and restarts from 0.
- R9: `result_o` holds its value on every edge that does not capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_ge_i | input | 1 | Comparator: high when the DAC voltage is at least the analogue input |
| dac_code_o | output | 6 | Ramp code sent to the DAC (the counter value) |
| result_o | output | 6 | Most recently captured conversion result |
| done_o | output | 1 | One-cycle strobe after each result update |

## Verification
The hardest condition to reach from the ports is a ramp that reaches code 63 with the comparator still low. A physical input within range always trips the comparator by that code. The bench's comparator model therefore has a hold-low control that suppresses tripping for one whole ramp, which exercises the forced capture of 63 and the restart that follows. The other demanding cases are inputs at exact 0.1 V multiples and a 0 V input, where the comparator trips on code 0. These are covered by the vector table and a sweep that also counts the cycles of each ramp.

// File: rtl/ramp_adc_pkg.sv
// Package: shared widths and helpers for the ramp converter.
// Assumes: codes are unsigned; the full-scale code is all ones.
package ramp_adc_pkg;

    localparam int unsigned RAMP_CODE_W = 6;

    // Full-scale code for a given width
    function automatic logic [31:0] full_scale(input int unsigned width);
        return (32'd1 << width) - 32'd1;
    endfunction

endpackage

// File: rtl/ramp_toggle_counter.sv
// Module: ramp_toggle_counter
// Counts upward by one per enabled clock. Each bit toggles when all lower
// bits are high. A clear request takes priority over counting.
// Assumes: the caller never counts past full scale (it clears there instead).
module ramp_toggle_counter #(
    parameter int unsigned WIDTH = ramp_adc_pkg::RAMP_CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             clear,
    output logic [WIDTH-1:0] count_q
);

    logic [WIDTH:0]   lower_all_high;
    logic [WIDTH-1:0] toggle_mask;
    logic [WIDTH-1:0] count_d;

    assign lower_all_high[0] = 1'b1;

    // Per-bit toggle enables built as an AND chain over the lower bits
    genvar k;
    generate
        for (k = 0; k < WIDTH; k++) begin : g_bit
            assign lower_all_high[k+1] = lower_all_high[k] & count_q[k];
            assign toggle_mask[k]      = lower_all_high[k] & step_en;
            assign count_d[k]          = clear ? 1'b0 : (count_q[k] ^ toggle_mask[k]);
        end
    endgenerate

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !clear) |=> count_q == WIDTH'($past(count_q) + 1'b1));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count_q == '0);

endmodule

// File: rtl/ramp_capture_reg.sv
// Module: ramp_capture_reg
// Parallel-load result register with a done strobe that follows each load.
// Assumes: load is a single-cycle decision made by the sequencer.
module ramp_capture_reg #(
    parameter int unsigned WIDTH = ramp_adc_pkg::RAMP_CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] result_q,
    output logic             done_q
);

    // Result register: load on capture, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    result_q <= '0;
        else if (load) result_q <= load_val;
    end

    // Done strobe: high for the cycle after a load
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= load;
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(result_q));

    assert_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !done_q);

endmodule

// File: rtl/ramp_sequencer.sv
// Module: ramp_sequencer
// Decides, on each cycle, whether the ramp steps or captures and restarts.
// Capture happens when the comparator trips or the code is at full scale.
// Assumes: the comparator is sampled for the code present this cycle.
module ramp_sequencer #(
    parameter int unsigned WIDTH = ramp_adc_pkg::RAMP_CODE_W
) (
    input  logic [WIDTH-1:0] code,
    input  logic             cmp_ge,
    output logic             capture,
    output logic             step
);

    localparam logic [WIDTH-1:0] TOP_CODE = WIDTH'(ramp_adc_pkg::full_scale(WIDTH));

    logic at_top;

    // Capture / step decision
    always_comb begin
        at_top  = (code == TOP_CODE);
        capture = cmp_ge | at_top;
        step    = ~capture;
    end

endmodule

// File: rtl/ramp_adc_ctrl.sv
// Module: ramp_adc_ctrl (top)
// Digital controller of a counting-ramp converter. The counter value drives
// the DAC. A comparator trip or full scale loads the result register, pulses
// done and restarts the ramp at zero.
// Assumes: the DAC settles within one clock and the comparator is synchronous.
module ramp_adc_ctrl #(
    parameter int unsigned CODE_W = ramp_adc_pkg::RAMP_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_ge_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic [CODE_W-1:0] result_o,
    output logic              done_o
);

    localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(ramp_adc_pkg::full_scale(CODE_W));

    logic [CODE_W-1:0] code_q;
    logic              capture;
    logic              step;

    ramp_sequencer #(.WIDTH(CODE_W)) u_seq (
        .code    (code_q),
        .cmp_ge  (cmp_ge_i),
        .capture (capture),
        .step    (step)
    );

    ramp_toggle_counter #(.WIDTH(CODE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step),
        .clear   (capture),
        .count_q (code_q)
    );

    ramp_capture_reg #(.WIDTH(CODE_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (capture),
        .load_val (code_q),
        .result_q (result_o),
        .done_q   (done_o)
    );

    assign dac_code_o = code_q;

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (dac_code_o == '0 && result_o == '0 && !done_o));

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_ge_i |=> (done_o && result_o == $past(dac_code_o)));

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> dac_code_o == '0);

    assert_top_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code_o == TOP_CODE) |=> (done_o && result_o == TOP_CODE && dac_code_o == '0));

endmodule

// File: tb/ramp_adc_ctrl_tb.sv
module ramp_adc_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] dac_code_o;
    logic [5:0] result_o;
    logic       done_o;
    int         vin_mv = 6300;
    bit         hold_low = 1'b0;
    logic       cmp_ge;
    int         tests = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    // Behavioural DAC (100 mV per code) and comparator
    assign cmp_ge = !hold_low && ((int'(dac_code_o) * 100) >= vin_mv);

    ramp_adc_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_ge_i   (cmp_ge),
        .dac_code_o (dac_code_o),
        .result_o   (result_o),
        .done_o     (done_o)
    );

    localparam int NV = 16;
    localparam int VEC_MV  [NV] = '{0, 1, 50, 99, 100, 101, 150, 250, 999, 1000, 2345, 3150, 4001, 5555, 6299, 6300};
    localparam int VEC_EXP [NV] = '{0, 1, 1, 1, 1, 2, 2, 3, 10, 10, 24, 32, 41, 56, 63, 63};

    task automatic chk(input int act, input int exp, input string req);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sync_done();
        int guard = 0;
        while (!done_o && guard < 300) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // One conversion; called at a negedge where done_o is high
    task automatic convert(input int mv, input int exp_code);
        int n = 0;
        vin_mv = mv;
        do begin
            @(negedge clk);
            n++;
            if (!done_o) chk(int'(dac_code_o), n, "R2 ramp step");
        end while (!done_o && n < 200);
        chk(n, exp_code + 1, "R7 edges to capture");
        chk(int'(result_o), exp_code, "R6/R3 result");
        chk(int'(dac_code_o), 0, "R4 restart");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(int'(dac_code_o), 0, "R1 code");
        chk(int'(result_o), 0, "R1 result");
        chk(int'(done_o), 0, "R1 done");
        rst_n = 1'b1;
        sync_done();

        // Vector table
        for (int i = 0; i < NV; i++) convert(VEC_MV[i], VEC_EXP[i]);

        // Sweep: exact multiples and points just below them
        for (int k = 0; k <= 63; k++) begin
            convert(k * 100, k);
            if (k > 0) convert(k * 100 - 30, k);
        end

        // R5 / R9: strobe falls and the result holds after a capture
        convert(2000, 20);
        vin_mv = 6300;
        @(negedge clk);
        chk(int'(done_o), 0, "R5 single-cycle strobe");
        chk(int'(result_o), 20, "R9 result held");
        repeat (5) @(negedge clk);
        chk(int'(result_o), 20, "R9 result held mid-ramp");
        sync_done();

        // R8: comparator held low for a whole ramp
        hold_low = 1'b1;
        convert(6300, 63);
        hold_low = 1'b0;
        convert(700, 7);

        // R7: 0 V input captures on every edge
        convert(0, 0);
        @(negedge clk);
        chk(int'(done_o), 1, "R7 repeated zero capture");
        chk(int'(result_o), 0, "R7 zero result");

        // R1: reset in the middle of a ramp
        vin_mv = 6300;
        @(negedge clk);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(int'(dac_code_o), 0, "R1 code mid-ramp");
        chk(int'(result_o), 0, "R1 result mid-ramp");
        chk(int'(done_o), 0, "R1 done mid-ramp");
        rst_n = 1'b1;
        sync_done();
        convert(3333, 34);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule